// File: doc/BRIEF.md
# Stack and Register-Pair Engine

This block keeps the working registers of a small 8-bit processor core. It holds six general byte registers, the accumulator and its flags byte, and a 16-bit stack pointer. It carries out the operations that move register pairs to and from a byte-wide stack in memory, swap the HL pair with the top of the stack, load the pointer from HL, step a pair up or down as one 16-bit value, and swap DE with HL. Instruction decode, the ALU and interrupt handling sit outside it.

An operation starts with a one-cycle `start` pulse that carries an operation code and a pair selector. The engine drives a synchronous memory port and makes at most one access per cycle. Read data returns on the cycle after the read strobe. When the operation is finished, the engine raises `done` for one cycle. The register file has one write port and one read port for the surrounding core, and the stack pointer is always visible.

Top module: `stk_engine`

## Requirements
- R1: After reset, every byte register reads 0, `sp_out` equals the `RESET_SP` parameter (default 16'h0000), and `busy`, `done`, `mem_we` and `mem_re` are low.
- R2: Register indices are B=0, C=1, D=2, E=3, H=4, L=5, F(flags)=6, A=7. When the engine is idle and `start` is low, a `reg_we` cycle writes `reg_wdata` into `reg_idx`. `rd_data` shows the register chosen by `rd_idx`.
- R3: Pair selector encoding is 0=BC, 1=DE, 2=HL, 3=AF, and the first-named register of each pair is the high byte. Push (op 0) first writes the high byte at SP-1 and then the low byte at SP-2, where A is the high byte and F the low byte of pair 3. SP ends two lower, modulo 65536.
- R4: Pop (op 1) reads the byte at SP into the low register and the byte at SP+1 into the high register. SP ends two higher, modulo 65536.
- R5: Stack exchange (op 2) swaps L with memory at SP and H with memory at SP+1. SP does not change.
- R6: Pointer load (op 3) sets SP to {H, L} and leaves H and L unchanged.
- R7: Increment (op 4) and decrement (op 5) treat the selected pair as one 16-bit value, with selector 3 meaning SP. They wrap modulo 65536 and leave F and every other register unchanged.
- R8: Pair swap (op 6) exchanges H with D and L with E in one operation.
- R9: A `start` that arrives while `busy` is high is ignored.
- R10: `done` is high for exactly one cycle. Counted in clock edges from the edge that samples `start`, it appears 1 edge later for ops 3 to 7, 3 edges later for push and pop, and 5 edges later for the stack exchange. Op 7 changes nothing.
- R11: `mem_we` and `mem_re` are never high together, and both stay low while the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (sampled when idle) |
| op | input | 3 | Operation code |
| pair | input | 2 | Pair selector |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register write index |
| reg_wdata | input | 8 | Register write data |
| rd_idx | input | 3 | Register read index |
| rd_data | output | 8 | Register read data |
| sp_out | output | 16 | Current stack pointer |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_rdata | input | 8 | Memory read data, valid the cycle after `mem_re` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Push is swept over all four pairs with distinct high and low bytes, from stack pointers that include 0x0001 and 0x0000. This separates the high/low write order and exposes any pointer wrap error. Pops follow two stacked pushes and load pairs other than the ones pushed, which tells a correct byte order apart from a mirrored one. Increment and decrement run on every selector, including SP, with 0x0000, 0xFFFF, 0x00FF and 0x0100, so a carry that fails to cross between the bytes shows up. A start raised during a push with an increment request tells an engine that ignores it apart from one that queues or accepts it.

// File: rtl/stk_pkg.sv
package stk_pkg;
    localparam int unsigned DW   = 8;
    localparam int unsigned AW   = 2 * DW;
    localparam int unsigned NREG = 8;
    localparam int unsigned IW   = $clog2(NREG);

    typedef logic [DW-1:0] byte_t;
    typedef logic [AW-1:0] word_t;

    typedef enum logic [2:0] {
        OP_PUSH = 3'd0,
        OP_POP  = 3'd1,
        OP_XSTK = 3'd2,
        OP_SPLD = 3'd3,
        OP_INC  = 3'd4,
        OP_DEC  = 3'd5,
        OP_SWAP = 3'd6,
        OP_NONE = 3'd7
    } op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PUSH_HI,
        S_PUSH_LO,
        S_POP_LO,
        S_POP_HI,
        S_POP_END,
        S_X_RD0,
        S_X_RD1,
        S_X_WR0,
        S_X_WR1,
        S_FIN
    } st_e;

    localparam logic [IW-1:0] IX_B = 3'd0;
    localparam logic [IW-1:0] IX_C = 3'd1;
    localparam logic [IW-1:0] IX_D = 3'd2;
    localparam logic [IW-1:0] IX_E = 3'd3;
    localparam logic [IW-1:0] IX_H = 3'd4;
    localparam logic [IW-1:0] IX_L = 3'd5;
    localparam logic [IW-1:0] IX_F = 3'd6;
    localparam logic [IW-1:0] IX_A = 3'd7;

    function automatic logic [IW-1:0] hi_of(input logic [1:0] p);
        case (p)
            2'd0:    return IX_B;
            2'd1:    return IX_D;
            2'd2:    return IX_H;
            default: return IX_A;
        endcase
    endfunction

    function automatic logic [IW-1:0] lo_of(input logic [1:0] p);
        case (p)
            2'd0:    return IX_C;
            2'd1:    return IX_E;
            2'd2:    return IX_L;
            default: return IX_F;
        endcase
    endfunction

    typedef struct packed {
        st_e                    st;
        logic [1:0]             pair;
        logic [NREG-1:0][DW-1:0] regs;
        word_t                  sp;
        byte_t                  tmp_lo;
        byte_t                  tmp_hi;
    } core_t;
endpackage

// File: rtl/stk_step.sv
module stk_step #(
    parameter int unsigned W    = 16,
    parameter bit          DOWN = 1'b0
) (
    input  logic [W-1:0] a,
    output logic [W-1:0] y
);
    generate
        if (DOWN) begin : g_down
            assign y = a - W'(1);
        end else begin : g_up
            assign y = a + W'(1);
        end
    endgenerate
endmodule

// File: rtl/stk_rdmux.sv
module stk_rdmux #(
    parameter int unsigned N = 8,
    parameter int unsigned W = 8,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0][W-1:0] regs,
    input  logic [IW-1:0]       idx,
    output logic [W-1:0]        q
);
    assign q = regs[idx];
endmodule

// File: rtl/stk_engine.sv
module stk_engine
    import stk_pkg::*;
#(
    parameter word_t RESET_SP = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    op,
    input  logic [1:0]    pair,
    input  logic          reg_we,
    input  logic [IW-1:0] reg_idx,
    input  logic [DW-1:0] reg_wdata,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] sp_out,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    output logic          mem_re,
    input  logic [DW-1:0] mem_rdata,
    output logic          busy,
    output logic          done
);
    core_t q, d;

    logic [IW-1:0] hi_i, lo_i, in_hi_i, in_lo_i;
    word_t         sel_w, sel_inc, sel_dec, sp_inc, sp_dec;

    assign hi_i    = hi_of(q.pair);
    assign lo_i    = lo_of(q.pair);
    assign in_hi_i = hi_of(pair);
    assign in_lo_i = lo_of(pair);
    assign sel_w   = (pair == 2'd3) ? q.sp : {q.regs[in_hi_i], q.regs[in_lo_i]};

    stk_step #(.W(AW), .DOWN(1'b0)) u_sp_inc  (.a(q.sp),  .y(sp_inc));
    stk_step #(.W(AW), .DOWN(1'b1)) u_sp_dec  (.a(q.sp),  .y(sp_dec));
    stk_step #(.W(AW), .DOWN(1'b0)) u_sel_inc (.a(sel_w), .y(sel_inc));
    stk_step #(.W(AW), .DOWN(1'b1)) u_sel_dec (.a(sel_w), .y(sel_dec));

    stk_rdmux #(.N(NREG), .W(DW)) u_rd (
        .regs (q.regs),
        .idx  (rd_idx),
        .q    (rd_data)
    );

    always_comb begin
        d         = q;
        mem_addr  = '0;
        mem_wdata = '0;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        done      = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (start) begin
                    d.pair = pair;
                    case (op_e'(op))
                        OP_PUSH: d.st = S_PUSH_HI;
                        OP_POP:  d.st = S_POP_LO;
                        OP_XSTK: d.st = S_X_RD0;
                        OP_SPLD: begin
                            d.sp = {q.regs[IX_H], q.regs[IX_L]};
                            d.st = S_FIN;
                        end
                        OP_INC: begin
                            if (pair == 2'd3) begin
                                d.sp = sel_inc;
                            end else begin
                                d.regs[in_hi_i] = sel_inc[AW-1:DW];
                                d.regs[in_lo_i] = sel_inc[DW-1:0];
                            end
                            d.st = S_FIN;
                        end
                        OP_DEC: begin
                            if (pair == 2'd3) begin
                                d.sp = sel_dec;
                            end else begin
                                d.regs[in_hi_i] = sel_dec[AW-1:DW];
                                d.regs[in_lo_i] = sel_dec[DW-1:0];
                            end
                            d.st = S_FIN;
                        end
                        OP_SWAP: begin
                            d.regs[IX_H] = q.regs[IX_D];
                            d.regs[IX_D] = q.regs[IX_H];
                            d.regs[IX_L] = q.regs[IX_E];
                            d.regs[IX_E] = q.regs[IX_L];
                            d.st         = S_FIN;
                        end
                        default: d.st = S_FIN;
                    endcase
                end else if (reg_we) begin
                    d.regs[reg_idx] = reg_wdata;
                end
            end
            S_PUSH_HI: begin
                mem_addr  = sp_dec;
                mem_wdata = q.regs[hi_i];
                mem_we    = 1'b1;
                d.sp      = sp_dec;
                d.st      = S_PUSH_LO;
            end
            S_PUSH_LO: begin
                mem_addr  = sp_dec;
                mem_wdata = q.regs[lo_i];
                mem_we    = 1'b1;
                d.sp      = sp_dec;
                d.st      = S_FIN;
            end
            S_POP_LO: begin
                mem_addr = q.sp;
                mem_re   = 1'b1;
                d.st     = S_POP_HI;
            end
            S_POP_HI: begin
                d.regs[lo_i] = mem_rdata;
                mem_addr     = sp_inc;
                mem_re       = 1'b1;
                d.sp         = sp_inc;
                d.st         = S_POP_END;
            end
            S_POP_END: begin
                d.regs[hi_i] = mem_rdata;
                d.sp         = sp_inc;
                done         = 1'b1;
                d.st         = S_IDLE;
            end
            S_X_RD0: begin
                mem_addr = q.sp;
                mem_re   = 1'b1;
                d.st     = S_X_RD1;
            end
            S_X_RD1: begin
                d.tmp_lo = mem_rdata;
                mem_addr = sp_inc;
                mem_re   = 1'b1;
                d.st     = S_X_WR0;
            end
            S_X_WR0: begin
                d.tmp_hi  = mem_rdata;
                mem_addr  = q.sp;
                mem_wdata = q.regs[IX_L];
                mem_we    = 1'b1;
                d.st      = S_X_WR1;
            end
            S_X_WR1: begin
                mem_addr     = sp_inc;
                mem_wdata    = q.regs[IX_H];
                mem_we       = 1'b1;
                d.regs[IX_L] = q.tmp_lo;
                d.regs[IX_H] = q.tmp_hi;
                d.st         = S_FIN;
            end
            S_FIN: begin
                done = 1'b1;
                d.st = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st     <= S_IDLE;
            q.pair   <= '0;
            q.regs   <= '0;
            q.sp     <= RESET_SP;
            q.tmp_lo <= '0;
            q.tmp_hi <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy   = (q.st != S_IDLE);
    assign sp_out = q.sp;
endmodule

// File: rtl/stk_engine_chk.sv
module stk_engine_chk
    import stk_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          mem_we,
    input logic          mem_re,
    input logic [AW-1:0] sp_out
);
    // R11: a single access per cycle
    a_r11_one_access: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    // R11: memory port silent while idle
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_we && !mem_re));

    // R10: completion pulse lasts one cycle
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: completion belongs to an operation in progress
    a_r10_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R4: pointer moves by at most one per cycle during an operation
    a_r4_sp_step: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ((sp_out == $past(sp_out)) ||
                  (sp_out == AW'($past(sp_out) + AW'(1))) ||
                  (sp_out == AW'($past(sp_out) - AW'(1)))));
endmodule

bind stk_engine stk_engine_chk chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy   (busy),
    .done   (done),
    .mem_we (mem_we),
    .mem_re (mem_re),
    .sp_out (sp_out)
);

// File: tb/stk_engine_tb.sv
module stk_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = '0;
    logic [1:0]  pair = '0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_idx = '0;
    logic [7:0]  reg_wdata = '0;
    logic [2:0]  rd_idx = '0;
    logic [7:0]  rd_data;
    logic [15:0] sp_out, mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we, mem_re;
    logic [7:0]  mem_rdata = '0;
    logic        busy, done;

    logic [7:0]  mem [0:255];
    logic [7:0]  mdl [0:7];
    logic [15:0] msp;
    int          n_chk = 0;
    int          n_err = 0;

    always #10 clk = ~clk;

    stk_engine dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .pair(pair),
        .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
        .rd_idx(rd_idx), .rd_data(rd_data), .sp_out(sp_out),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_re(mem_re), .mem_rdata(mem_rdata), .busy(busy), .done(done)
    );

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R11 monitor at the ports
    always @(negedge clk) begin
        if (rst_n && ((mem_we && mem_re) || (!busy && (mem_we || mem_re))))
            chk("R11 access overlap or idle access", {mem_we, mem_re, busy}, 3'b001);
    end

    function automatic logic [2:0] hix(input int p);
        return (p == 0) ? 3'd0 : (p == 1) ? 3'd2 : (p == 2) ? 3'd4 : 3'd7;
    endfunction
    function automatic logic [2:0] lix(input int p);
        return (p == 0) ? 3'd1 : (p == 1) ? 3'd3 : (p == 2) ? 3'd5 : 3'd6;
    endfunction

    task automatic wr_reg(input logic [2:0] i, input logic [7:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_idx = i; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
        mdl[i] = v;
    endtask

    task automatic rd_reg(input logic [2:0] i, output logic [7:0] v);
        rd_idx = i;
        #1;
        v = rd_data;
    endtask

    task automatic check_regs(input string req);
        logic [7:0] v;
        for (int i = 0; i < 8; i++) begin
            rd_reg(3'(i), v);
            chk(req, v, mdl[i]);
        end
        chk(req, sp_out, msp);
    endtask

    task automatic run_op(input logic [2:0] o, input logic [1:0] p, input int exp_lat, input string req);
        int lat;
        @(negedge clk);
        start = 1'b1; op = o; pair = p;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        chk({req, " R10 latency"}, lat, exp_lat);
        @(negedge clk);
        chk("R10 done single cycle", done, 1'b0);
    endtask

    task automatic set_sp(input logic [15:0] v);
        wr_reg(3'd4, v[15:8]);
        wr_reg(3'd5, v[7:0]);
        run_op(3'd3, 2'd0, 1, "R6");
        msp = v;
    endtask

    task automatic set_pair(input int p, input logic [15:0] v);
        if (p == 3) set_sp(v);
        else begin
            wr_reg(hix(p), v[15:8]);
            wr_reg(lix(p), v[7:0]);
        end
    endtask

    function automatic logic [15:0] get_pair_mdl(input int p);
        return (p == 3) ? msp : {mdl[hix(p)], mdl[lix(p)]};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL R10 watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] spv [0:3];
        logic [15:0] vals [0:4];
        logic [15:0] sp0, got;
        logic [7:0]  v, hv, lv;
        spv[0] = 16'h0080; spv[1] = 16'h0001; spv[2] = 16'h0000; spv[3] = 16'h10F0;
        vals[0] = 16'h0000; vals[1] = 16'hFFFF; vals[2] = 16'h00FF; vals[3] = 16'h0100; vals[4] = 16'h1234;
        for (int i = 0; i < 8; i++) mdl[i] = 8'h00;
        msp = 16'h0000;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 busy", busy, 1'b0);
        chk("R1 done", done, 1'b0);
        chk("R1 strobes", {mem_we, mem_re}, 2'b00);
        check_regs("R1 regs/sp");

        // R2 register port
        for (int i = 0; i < 8; i++) wr_reg(3'(i), 8'(8'h11 * (i + 1)));
        check_regs("R2 write/read");

        // R6 pointer load, HL kept
        for (int k = 0; k < 4; k++) begin
            set_sp(spv[k]);
            check_regs("R6 sp from HL");
        end

        // R3 push sweep
        for (int p = 0; p < 4; p++) begin
            for (int k = 0; k < 4; k++) begin
                set_sp(spv[k]);
                hv = 8'(p * 53 + k * 29 + 7);
                lv = 8'(p * 17 + k * 71 + 200);
                wr_reg(hix(p), hv);
                wr_reg(lix(p), lv);
                sp0 = msp;
                run_op(3'd0, 2'(p), 3, "R3");
                msp = sp0 - 16'd2;
                chk("R3 high byte at SP-1", mem[8'(sp0 - 16'd1)], hv);
                chk("R3 low byte at SP-2", mem[8'(sp0 - 16'd2)], lv);
                check_regs("R3 regs/sp");
            end
        end

        // R4 pop after two pushes into other pairs
        for (int k = 0; k < 4; k++) begin
            set_sp(spv[k]);
            set_pair(0, 16'hB0C0 + 16'(k));
            set_pair(1, 16'hD0E0 + 16'(k * 3));
            run_op(3'd0, 2'd0, 3, "R3");
            run_op(3'd0, 2'd1, 3, "R3");
            msp = msp - 16'd4;
            run_op(3'd1, 2'd2, 3, "R4");
            mdl[4] = mdl[2]; mdl[5] = mdl[3]; msp = msp + 16'd2;
            check_regs("R4 pop into HL");
            run_op(3'd1, 2'd3, 3, "R4");
            mdl[7] = mdl[0]; mdl[6] = mdl[1]; msp = msp + 16'd2;
            check_regs("R4 pop into AF");
        end

        // R5 exchange with top of stack
        for (int k = 0; k < 4; k++) begin
            set_sp(spv[k]);
            set_pair(1, 16'h4A5B + 16'(k * 257));
            run_op(3'd0, 2'd1, 3, "R3");
            msp = msp - 16'd2;
            hv = 8'(8'h90 + k); lv = 8'(8'h60 + k);
            wr_reg(3'd4, hv);
            wr_reg(3'd5, lv);
            sp0 = msp;
            run_op(3'd2, 2'd0, 5, "R5");
            mdl[5] = mdl[3]; mdl[4] = mdl[2];
            check_regs("R5 HL from stack, SP kept");
            chk("R5 L to SP", mem[sp0[7:0]], lv);
            chk("R5 H to SP+1", mem[8'(sp0 + 16'd1)], hv);
        end

        // R7 pair step up/down, flags untouched
        wr_reg(3'd6, 8'hA5);
        for (int p = 0; p < 4; p++) begin
            for (int k = 0; k < 5; k++) begin
                set_pair(p, vals[k]);
                run_op(3'd4, 2'(p), 1, "R7");
                got = vals[k] + 16'd1;
                if (p == 3) msp = got; else begin mdl[hix(p)] = got[15:8]; mdl[lix(p)] = got[7:0]; end
                chk("R7 increment", get_pair_mdl(p), got);
                check_regs("R7 after increment");
                set_pair(p, vals[k]);
                run_op(3'd5, 2'(p), 1, "R7");
                got = vals[k] - 16'd1;
                if (p == 3) msp = got; else begin mdl[hix(p)] = got[15:8]; mdl[lix(p)] = got[7:0]; end
                check_regs("R7 after decrement");
            end
        end

        // R8 DE/HL swap
        for (int k = 0; k < 3; k++) begin
            set_pair(1, 16'h1357 + 16'(k * 4099));
            set_pair(2, 16'hFEDC - 16'(k * 771));
            run_op(3'd6, 2'd0, 1, "R8");
            v = mdl[2]; mdl[2] = mdl[4]; mdl[4] = v;
            v = mdl[3]; mdl[3] = mdl[5]; mdl[5] = v;
            check_regs("R8 swap");
        end

        // R10 op 7 changes nothing
        run_op(3'd7, 2'd2, 1, "R10");
        check_regs("R10 no-op");

        // R9 start during busy ignored
        set_sp(16'h0040);
        set_pair(0, 16'h22EE);
        @(negedge clk);
        start = 1'b1; op = 3'd0; pair = 2'd0;
        @(negedge clk);
        op = 3'd4;
        chk("R9 busy after start", busy, 1'b1);
        @(negedge clk);
        @(negedge clk);
        chk("R9 done of push", done, 1'b1);
        start = 1'b0;
        @(negedge clk);
        chk("R9 no second operation", {busy, done}, 2'b00);
        msp = 16'h003E;
        check_regs("R9 BC not incremented");
        chk("R9 push high byte", mem[8'h3F], 8'h22);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule